// File: doc/BRIEF.md
# Peak-Time Hit Classifier

This block takes one hit strip at a time, each with six pedestal-corrected time samples and a strip number, and turns it into a compact output record. It finds the largest sample and the sample index where it occurs. When the pulse shape gives a trustworthy time, the strip is reported as one word carrying the amplitude and the time index. When the shape is doubtful, the same word goes out with a samples-next flag raised, and two further words carrying all six samples follow it. A downstream packer can therefore work out each record's length from its first word alone.

Both sides use a valid/ready handshake. While the two sample words of a doubtful hit are still waiting to leave, input is held off, so only one hit is in flight. A good hit can be accepted in every cycle. The dip margin used by the pile-up rule is a static configuration input.

Top module: `hit_peak_classifier`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The amplitude field of the hit word equals the largest of the six input samples.
- R3: The time field is the index (0..5) of the largest sample, where sample i is in_samples[8i+7:8i]. When several samples share the largest value, the lowest index is reported.
- R4: A hit whose reported time index is 0 or 5 is doubtful, so its samples-next flag is 1.
- R5: A hit is also doubtful when some sample at index j (1..4) lies strictly more than dip_margin below both the largest sample before it and the largest sample after it. Any hit that meets neither R4 nor R5 carries samples-next 0 and produces no sample words.
- R6: A doubtful hit's word is followed directly by two sample words. Word 0 holds samples 0,1,2 and word 1 holds samples 3,4,5, with sample m of a word in bits [8m+7:8m].
- R7: The hit word layout is: bits 2:0 time, 10:3 amplitude, 17:11 strip number, 18 samples-next, 23:19 zero. out_last is 1 only on the final word of each hit, which is the hit word for a good hit and the second sample word for a doubtful one.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold steady. N accepted hits produce exactly N words plus 2 for each doubtful hit, in acceptance order.
- R9: While an output word that is not the last of its hit is presented, in_ready is 0.
- R10: A hit accepted at a clock edge has its first word on the output straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dip_margin | input | 8 | Minimum dip depth (exclusive) that marks a double peak |
| in_valid | input | 1 | Hit offered |
| in_ready | output | 1 | Hit can be taken this cycle |
| in_strip | input | 7 | Strip number of the hit |
| in_samples | input | 48 | Six 8-bit samples, sample i in bits [8i+7:8i] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 24 | Hit word or sample word |
| out_last | output | 1 | Final word of the current hit |

## Verification
Classification is combinational on the input and is registered together with the hit. A hit accepted at one edge therefore shows its first word in the next cycle, and each sample word comes one accepted word later. The bench samples every port 1 ns after the falling edge. It records a transfer only where valid and ready are both high at that point, and it compares the presented word at the moment it is taken against a queue built from its own arithmetic model. Stall holding, input hold-off and next-cycle appearance are each checked one sampling point after the cycle that caused them.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    parameter int SAMP_W   = 8;
    parameter int NSAMP    = 6;
    parameter int STRIP_W  = 7;
    parameter int PER_WORD = NSAMP / 2;
    localparam int TIME_W  = $clog2(NSAMP);
    localparam int WORD_W  = PER_WORD * SAMP_W;
    localparam int HIT_W   = 1 + STRIP_W + SAMP_W + TIME_W;
    localparam int PAD_W   = WORD_W - HIT_W;

    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIT  = 2'd1,
        PH_SW0  = 2'd2,
        PH_SW1  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e                   phase;
        logic [STRIP_W-1:0]       strip;
        samp_t                    peak;
        logic [TIME_W-1:0]        ptime;
        logic                     snext;
        samp_t [NSAMP-1:0]        samps;
    } emit_state_t;
endpackage

// File: rtl/hpc_peak_find.sv
module hpc_peak_find #(
    parameter int N  = 6,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [N*W-1:0] samps,
    output logic [W-1:0]   peak,
    output logic [IW-1:0]  idx
);
    always_comb begin
        peak = samps[W-1:0];
        idx  = '0;
        for (int i = 1; i < N; i++) begin
            // strict compare keeps the earliest index on ties
            if (samps[i*W +: W] > peak) begin
                peak = samps[i*W +: W];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hpc_dip_detect.sv
module hpc_dip_detect #(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic [N*W-1:0] samps,
    input  logic [W-1:0]   margin,
    output logic           double_peak
);
    logic [W-1:0] s   [0:N-1];
    logic [W-1:0] pre [0:N-3];
    logic [W-1:0] suf [2:N-1];
    logic [N-2:1] dip;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign s[g] = samps[g*W +: W];
    end

    assign pre[0] = s[0];
    for (genvar g = 1; g <= N-3; g++) begin : g_pre
        assign pre[g] = (s[g] > pre[g-1]) ? s[g] : pre[g-1];
    end

    assign suf[N-1] = s[N-1];
    for (genvar g = N-2; g >= 2; g--) begin : g_suf
        assign suf[g] = (s[g] > suf[g+1]) ? s[g] : suf[g+1];
    end

    for (genvar g = 1; g <= N-2; g++) begin : g_dip
        assign dip[g] = (pre[g-1] > s[g]) && (suf[g+1] > s[g])
                     && ((pre[g-1] - s[g]) > margin)
                     && ((suf[g+1] - s[g]) > margin);
    end

    assign double_peak = |dip;
endmodule

// File: rtl/hpc_emit.sv
module hpc_emit
    import hpc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [STRIP_W-1:0]   strip,
    input  samp_t                peak,
    input  logic [TIME_W-1:0]    ptime,
    input  logic                 bad,
    input  logic [NSAMP*SAMP_W-1:0] samps,
    input  logic                 out_ready,
    output logic                 can_load,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_last
);
    emit_state_t q, d;

    always_comb begin
        out_valid = (q.phase != PH_IDLE);
        out_last  = ((q.phase == PH_HIT) && !q.snext) || (q.phase == PH_SW1);
        can_load  = (q.phase == PH_IDLE) || (out_ready && out_last);

        out_data = '0;
        case (q.phase)
            PH_HIT: out_data = {{PAD_W{1'b0}}, q.snext, q.strip, q.peak, q.ptime};
            PH_SW0: for (int m = 0; m < PER_WORD; m++)
                        out_data[m*SAMP_W +: SAMP_W] = q.samps[m];
            PH_SW1: for (int m = 0; m < PER_WORD; m++)
                        out_data[m*SAMP_W +: SAMP_W] = q.samps[PER_WORD+m];
            default: out_data = '0;
        endcase

        d = q;
        if (out_valid && out_ready) begin
            case (q.phase)
                PH_HIT:  d.phase = q.snext ? PH_SW0 : PH_IDLE;
                PH_SW0:  d.phase = PH_SW1;
                default: d.phase = PH_IDLE;
            endcase
        end
        if (load) begin
            d.phase = PH_HIT;
            d.strip = strip;
            d.peak  = peak;
            d.ptime = ptime;
            d.snext = bad;
            for (int i = 0; i < NSAMP; i++)
                d.samps[i] = samps[i*SAMP_W +: SAMP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.strip <= '0;
            q.peak  <= '0;
            q.ptime <= '0;
            q.snext <= 1'b0;
            q.samps <= '0;
        end else begin
            q <= d;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !can_load);

    // R6
    sample_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    // R4
    edge_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_HIT) && ((q.ptime == '0) || (q.ptime == TIME_W'(NSAMP-1)))) |-> q.snext);

    // R3
    peak_at_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HIT) |-> ((q.ptime < TIME_W'(NSAMP)) && (q.samps[q.ptime] == q.peak)));

    for (genvar g = 0; g < NSAMP; g++) begin : g_cover
        // R2
        peak_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q.phase == PH_HIT) |-> (q.peak >= q.samps[g]));
    end
endmodule

// File: rtl/hit_peak_classifier.sv
module hit_peak_classifier
    import hpc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SAMP_W-1:0]           dip_margin,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [STRIP_W-1:0]          in_strip,
    input  logic [NSAMP*SAMP_W-1:0]     in_samples,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [WORD_W-1:0]           out_data,
    output logic                        out_last
);
    samp_t              peak;
    logic [TIME_W-1:0]  pidx;
    logic               dbl;
    logic               edge_max;
    logic               bad;
    logic               load;

    hpc_peak_find #(.N(NSAMP), .W(SAMP_W), .IW(TIME_W)) peak_i (
        .samps (in_samples),
        .peak  (peak),
        .idx   (pidx)
    );

    hpc_dip_detect #(.N(NSAMP), .W(SAMP_W)) dip_i (
        .samps       (in_samples),
        .margin      (dip_margin),
        .double_peak (dbl)
    );

    assign edge_max = (pidx == '0) || (pidx == TIME_W'(NSAMP-1));
    assign bad      = dbl || edge_max;
    assign load     = in_valid && in_ready;

    hpc_emit emit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .strip     (in_strip),
        .peak      (peak),
        .ptime     (pidx),
        .bad       (bad),
        .samps     (in_samples),
        .out_ready (out_ready),
        .can_load  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );
endmodule

// File: tb/hit_peak_classifier_tb.sv
`timescale 1ns/1ps
module hit_peak_classifier_tb_top;
    localparam int NHITS = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dip_margin = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_strip = '0;
    logic [47:0] in_samples = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_data;
    logic        out_last;

    always #2.5 clk = ~clk;

    hit_peak_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .dip_margin(dip_margin),
        .in_valid(in_valid), .in_ready(in_ready), .in_strip(in_strip),
        .in_samples(in_samples), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [24:0] expq[$];
    int          kindq[$];
    int          tagq[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic gen_hit(input int k, output logic [47:0] s);
        int mode, p, a, st, p1, p2, a1, a2, v, v2;
        mode = k % 4;
        step_rng(); p = int'(rng % 6); a = 100 + int'(rng[15:8] % 100); st = 1 + int'(rng[23:16] % 30);
        step_rng(); p1 = int'(rng % 3); p2 = 3 + int'(rng[9:8] % 3); a1 = 60 + int'(rng[23:16] % 150); a2 = 60 + int'(rng[31:24] % 150);
        for (int i = 0; i < 6; i++) begin
            step_rng();
            case (mode)
                0: v = int'(rng[7:0]);
                1: v = int'(rng % 4);
                2: begin v = a - st * absd(i, (k / 4) % 6); if (v < 0) v = 0; end
                default: begin
                    v = a1 - 20 * absd(i, p1); v2 = a2 - 20 * absd(i, p2);
                    if (v2 > v) v = v2;
                    if (v < 0) v = int'(rng % 10);
                end
            endcase
            s[i*8 +: 8] = 8'(v);
        end
        if (p > 6) s = '0;
    endtask

    task automatic push_expected(input logic [47:0] s, input logic [6:0] strip, input logic [7:0] m);
        int pk, ix, lm, rm, sj;
        logic bad;
        pk = int'(s[7:0]); ix = 0;
        for (int i = 1; i < 6; i++) if (int'(s[i*8 +: 8]) > pk) begin pk = int'(s[i*8 +: 8]); ix = i; end
        bad = (ix == 0) || (ix == 5);
        for (int j = 1; j < 5; j++) begin
            lm = 0; rm = 0; sj = int'(s[j*8 +: 8]);
            for (int i = 0; i < j; i++) if (int'(s[i*8 +: 8]) > lm) lm = int'(s[i*8 +: 8]);
            for (int i = j + 1; i < 6; i++) if (int'(s[i*8 +: 8]) > rm) rm = int'(s[i*8 +: 8]);
            if ((lm - sj > int'(m)) && (rm - sj > int'(m))) bad = 1'b1;
        end
        expq.push_back({!bad, 5'b0, bad, strip, 8'(pk), 3'(ix)});
        kindq.push_back(0);
        tagq.push_back((ix == 0 || ix == 5) ? 4 : 5);
        if (bad) begin
            expq.push_back({1'b0, s[23:0]}); kindq.push_back(1); tagq.push_back(6);
            expq.push_back({1'b1, s[47:24]}); kindq.push_back(2); tagq.push_back(6);
        end
    endtask

    initial begin : main
        logic [47:0] pend_s;
        logic        have_pend;
        logic        prev_stall, prev_in;
        logic [23:0] prev_data;
        logic [24:0] e;
        int          kind, tag, k, cycles;
        logic        in_x, out_x, done;
        logic [7:0]  margins [4];
        margins[0] = 8'd0; margins[1] = 8'd2; margins[2] = 8'd20; margins[3] = 8'd255;
        have_pend = 1'b0; prev_stall = 1'b0; prev_in = 1'b0; prev_data = '0;
        k = 0; cycles = 0; done = 1'b0; pend_s = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);

        while (!done) begin
            @(negedge clk);
            if (!have_pend && k < NHITS) begin
                gen_hit(k, pend_s);
                have_pend = 1'b1;
            end
            step_rng();
            dip_margin = margins[(k / 750) % 4];
            in_valid   = have_pend && (rng[3:0] != 4'd0) && (rng[5:4] != 2'd0);
            in_samples = pend_s;
            in_strip   = 7'(k);
            out_ready  = (rng[9:8] != 2'd0);
            #1;
            if (prev_stall) begin
                check("R8 valid held under stall", 32'(out_valid), 32'd1);
                check("R8 data held under stall", 32'(out_data), 32'(prev_data));
            end
            if (prev_in) check("R10 first word next cycle", 32'(out_valid), 32'd1);
            if (out_valid && !out_last) check("R9 input held off", 32'(in_ready), 32'd0);

            in_x  = in_valid && in_ready;
            out_x = out_valid && out_ready;
            if (out_x) begin
                if (expq.size() == 0) begin
                    check("R8 unexpected extra word", 32'(out_data), 32'hFFFF_FFFF);
                end else begin
                    e = expq.pop_front(); kind = kindq.pop_front(); tag = tagq.pop_front();
                    if (kind == 0) begin
                        check("R2 peak amplitude", 32'(out_data[10:3]), 32'(e[10:3]));
                        check("R3 peak time", 32'(out_data[2:0]), 32'(e[2:0]));
                        if (tag == 4) check("R4 edge peak flag", 32'(out_data[18]), 32'(e[18]));
                        else          check("R5 dip flag", 32'(out_data[18]), 32'(e[18]));
                        check("R7 strip and padding", 32'({out_data[23:19], out_data[17:11]}),
                              32'({e[23:19], e[17:11]}));
                        check("R7 last on hit word", 32'(out_last), 32'(e[24]));
                    end else begin
                        check("R6 sample word", 32'(out_data), 32'(e[23:0]));
                        check("R7 last on sample word", 32'(out_last), 32'(e[24]));
                    end
                end
            end
            if (in_x) begin
                push_expected(pend_s, in_strip, dip_margin);
                have_pend = 1'b0;
                k++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_in    = in_x;
            cycles++;
            if (k == NHITS && !have_pend && expq.size() == 0 && !out_valid) done = 1'b1;
            if (cycles > 150000) begin
                check("watchdog expired", 32'd1, 32'd0);
                done = 1'b1;
            end
        end
        check("R8 all expected words seen", 32'(expq.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule